// File: doc/BRIEF.md
# Zero-Prefill Priority Stream Merger

This block sits after a delay buffer in a feedback path and hides the buffer's start-up latency. After reset it can hand out a fixed number of zero samples, which keeps the consumer busy until the buffer has filled. Two sources feed one valid/ready output. The live input stream always wins when it offers a word. A counted zero source fills the cycles in which the input is idle.

The output carries only the sample value. It does not report which source supplied a word. Each zero is spent only when the consumer actually accepts it. Once all zeros are spent, the block is a plain pass-through of the input stream. A synchronous reset restores the full zero budget.

Top module: `zero_prefill_merge`

## Requirements
- R1: After reset, with the input idle and the output always ready, exactly FILL_NUM words with value zero leave the output.
- R2: Whenever in_valid is high, out_valid is high and out_data equals in_data in the same cycle.
- R3: When in_valid is low and zeros remain in the budget, out_valid is high and out_data is all zero bits.
- R4: A zero is spent only on a cycle with out_valid and out_ready high and the input idle. While out_ready is low, the pending zero stays offered and the budget is kept.
- R5: The zero budget is never spent in a cycle in which in_valid is high.
- R6: in_ready equals out_ready in every cycle.
- R7: Once the budget is spent and in_valid is low, out_valid is low.
- R8: A synchronous reset, including one asserted part way through the fill, restores the budget to FILL_NUM zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Live sample offered |
| in_ready | output | 1 | Live sample accepted when high with in_valid |
| in_data | input | DATA_W | Live sample value |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | DATA_W | Output sample value |

## Verification
A budget counter that is wrong in either direction changes how many zeros the output delivers. The error is visible at the first cycle in which out_valid stays high past the FILL_NUM-th accepted zero, or drops low before it. Spending zeros on stalled cycles or on cycles with live traffic shows up the same way: the consumer receives too few zeros when the input later goes idle. A wrong select shows up in the same cycle, as a zero in place of the live sample or as a mismatch between in_ready and out_ready.

// File: rtl/zpf_pkg.sv
package zpf_pkg;
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/zpf_fill_src.sv
module zpf_fill_src #(
  parameter int unsigned FILL_NUM = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  output logic pend
);
  localparam int unsigned CW = zpf_pkg::cnt_width(FILL_NUM);
  localparam logic [CW-1:0] LOAD = CW'(FILL_NUM);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)
      left_q <= LOAD;
    else if (take && left_q != '0)
      left_q <= left_q - 1'b1;
  end

  assign pend = (left_q != '0);

  AST_TAKE_ONLY_PEND: assert property (@(posedge clk) disable iff (rst)
    take |-> pend); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(left_q)); // R4
endmodule

// File: rtl/zpf_prio_sel.sv
module zpf_prio_sel #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              live_vld,
  input  logic [DATA_W-1:0] live_dat,
  input  logic              fill_pend,
  input  logic              sink_rdy,
  output logic              sel_vld,
  output logic [DATA_W-1:0] sel_dat,
  output logic              fill_take
);
  always_comb begin
    sel_vld   = live_vld | fill_pend;
    sel_dat   = live_vld ? live_dat : '0;
    fill_take = !live_vld && fill_pend && sink_rdy;
  end
endmodule

// File: rtl/zero_prefill_merge.sv
module zero_prefill_merge #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned FILL_NUM = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic pend, take;

  zpf_fill_src #(.FILL_NUM(FILL_NUM)) u_fill (
    .clk(clk), .rst(rst), .take(take), .pend(pend)
  );

  zpf_prio_sel #(.DATA_W(DATA_W)) u_sel (
    .live_vld(in_valid), .live_dat(in_data), .fill_pend(pend),
    .sink_rdy(out_ready), .sel_vld(out_valid), .sel_dat(out_data),
    .fill_take(take)
  );

  assign in_ready = out_ready;

  AST_LIVE_NO_SPEND: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> !take); // R5
  AST_EXHAUST_STAYS: assert property (@(posedge clk) disable iff (rst)
    !out_valid |=> (out_valid |-> in_valid)); // R7
  AST_STALL_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !in_valid) |=> (out_valid || in_valid)); // R4
  AST_LIVE_PASS: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (out_valid && out_data == in_data)); // R2
endmodule

// File: tb/sim_zero_prefill_merge.sv
module sim_zero_prefill_merge;
  localparam int DW = 16;
  localparam int NUM = 8;

  logic clk = 0, rst = 1;
  logic in_valid = 0, out_ready = 0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [DW-1:0] out_data;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  zero_prefill_merge #(.DATA_W(DW), .FILL_NUM(NUM)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // advance one edge, then place new inputs just after it
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst = 1; in_valid = 0; out_ready = 0; tick(); tick(); rst = 0;
  endtask

  // idle input, always ready: count delivered zeros
  task automatic drain(input int exp_n, input string req);
    int got = 0, nonzero = 0;
    in_valid = 0; out_ready = 1;
    for (int i = 0; i < exp_n + 4; i++) begin
      #1;
      if (out_valid) begin got++; if (out_data != 0) nonzero++; end
      tick();
    end
    chk(req, got, exp_n);
    chk({req, " zero value"}, nonzero, 0);
  endtask

  task automatic t_reset_state();
    do_reset(); out_ready = 1; #1;
    chk("R3 reset valid", out_valid, 1);
    chk("R3 reset data", out_data, 0);
    chk("R6 ready", in_ready, 1);
    drain(NUM, "R1 count");
    #1 chk("R7 idle low", out_valid, 0);
  endtask

  task automatic t_priority();
    do_reset(); out_ready = 1;
    for (int i = 0; i < 3; i++) begin
      in_valid = 1; in_data = DW'(16'hA5A0 + i); #1;
      chk("R2 valid", out_valid, 1);
      chk("R2 data", out_data, 16'hA5A0 + i);
      chk("R6 ready", in_ready, 1);
      tick();
    end
    drain(NUM, "R5 budget kept");
  endtask

  task automatic t_stall();
    do_reset(); out_ready = 0;
    for (int i = 0; i < 5; i++) begin
      #1;
      chk("R4 stall valid", out_valid, 1);
      chk("R6 ready low", in_ready, 0);
      tick();
    end
    drain(NUM, "R4 budget after stall");
  endtask

  task automatic t_mid_reset();
    do_reset(); out_ready = 1;
    tick(); tick(); tick();
    do_reset();
    drain(NUM, "R8 reload");
  endtask

  task automatic t_after();
    in_valid = 1; in_data = 16'h1234; out_ready = 0; #1;
    chk("R2 after fill", out_data, 16'h1234);
    chk("R6 stalled", in_ready, 0);
    tick(); in_valid = 0; #1;
    chk("R7 low", out_valid, 0);
    tick();
  endtask

  initial begin
    t_reset_state();
    t_priority();
    t_stall();
    t_mid_reset();
    t_after();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule